// File: doc/BRIEF.md
# Chained Predicate Logic Unit

This block keeps a file of two-bit condition flags and evaluates the flag logic of one wide instruction per clock. Each instruction can carry several flag operations. Each operation is tagged for one of two half-cycle groups. A second-group operation can read a flag that a first-group operation of the same instruction produces, so two dependent flag operations finish in a single clock. All writes from an instruction commit together at the clock edge.

The same instruction can also carry several qualifier selectors. Each selector names a flag and an optional negation. The block returns one registered enable bit per selector, one cycle later, so the enables line up with the execution stage that gates the other slots of the instruction. A plain external write port loads flags, and a combinational read port observes them.

Top module: `chained_pred_unit`

## Requirements
- R1: After synchronous reset every flag reads 2'b00 and every qualify enable is 0.
- R2: A flag holds its value in bit 0 and its validity in bit 1. The opcode 0 gives AND, 1 gives OR and 2 gives ANDN (first operand AND NOT second). Each operand's value bit is inverted first when its invert flag is set. Opcode 3 writes nothing.
- R3: If either operand of an operation is invalid, the result written is 2'b00. A valid result is 2'b1x, where x is the computed value.
- R4: An operation with group bit 0 reads the flag file. An operation with group bit 1 whose operand index matches the destination of a writing group-0 operation in the same instruction reads that result instead. If several group-0 operations match, the highest-numbered one is used.
- R5: All other operand reads, and all qualifier reads, see the flag file as it was before the instruction. Writes appear on the read port after the next rising edge.
- R6: When several writers target one flag in the same instruction, the highest-numbered slot wins, and any slot wins over the external write port.
- R7: When the external write port is enabled, it loads its data into the indexed flag if no slot writes that flag.
- R8: Qualify enable i is updated at the rising edge after its selector is presented. It is 1 when the selector is unused. Otherwise it is validity AND (value XOR negate).
- R9: A qualifier that selects an invalid flag gives enable 0, whatever its negate bit is.
- R10: The read port returns the indexed flag combinationally.
- R11: A slot whose valid bit is 0, or whose opcode is 3, leaves every flag unchanged, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_vld | input | NUM_SLOTS | Slot carries an operation |
| op_grp | input | NUM_SLOTS | Group bit: 0 first half, 1 second half |
| op_code | input | 2*NUM_SLOTS | Opcode per slot |
| op_src_a | input | NUM_SLOTS*IDX_W | First operand index per slot |
| op_inv_a | input | NUM_SLOTS | Invert first operand value |
| op_src_b | input | NUM_SLOTS*IDX_W | Second operand index per slot |
| op_inv_b | input | NUM_SLOTS | Invert second operand value |
| op_dst | input | NUM_SLOTS*IDX_W | Destination index per slot |
| wr_en | input | 1 | External write enable |
| wr_idx | input | IDX_W | External write index |
| wr_data | input | 2 | External write data |
| rd_idx | input | IDX_W | Read port index |
| rd_data | output | 2 | Read port data |
| qual_use | input | NUM_QUAL | Qualifier selector in use |
| qual_neg | input | NUM_QUAL | Negate selected value |
| qual_idx | input | NUM_QUAL*IDX_W | Flag index per qualifier |
| qual_en | output | NUM_QUAL | Registered enables |

## Verification
The assertions assume that reset is synchronous and that every input holds a known value at each rising edge, including the fields of idle slots and unused qualifiers. They also assume that every index is below the flag count. The stimulus changes inputs only on falling edges and sets every field from a fully initialised array, including on idle cycles. It draws indices from the valid range: 0 to 15 in the pseudo-random phase, so that writes collide often, and up to 31 in the reset sweep.

// File: rtl/cplu_pkg.sv
package cplu_pkg;

  typedef logic [1:0] pred_t;

  typedef enum logic [1:0] {
    PL_AND  = 2'd0,
    PL_OR   = 2'd1,
    PL_ANDN = 2'd2,
    PL_NOP  = 2'd3
  } pl_op_e;

  // Combine two flags; an invalid operand yields the all-zero flag.
  function automatic pred_t pl_eval(input pl_op_e op, input pred_t a, input pred_t b,
                                    input logic inv_a, input logic inv_b);
    logic x;
    logic y;
    logic r;
    if (!(a[1] && b[1])) return 2'b00;
    x = a[0] ^ inv_a;
    y = b[0] ^ inv_b;
    case (op)
      PL_AND:  r = x & y;
      PL_OR:   r = x | y;
      PL_ANDN: r = x & ~y;
      PL_NOP:  r = 1'b0;
    endcase
    return {1'b1, r};
  endfunction

  // Qualifier: true only for a valid flag whose (possibly negated) value is 1.
  function automatic logic qual_eval(input pred_t p, input logic neg);
    return p[1] & (p[0] ^ neg);
  endfunction

endpackage

// File: rtl/cplu_pred_file.sv
module cplu_pred_file #(
  parameter int NUM_PREGS = 32,
  parameter int NUM_SLOTS = 3,
  parameter int IDX_W     = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SLOTS-1:0]       slot_we,
  input  logic [NUM_SLOTS*IDX_W-1:0] slot_dst,
  input  logic [NUM_SLOTS*2-1:0]     slot_res,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [1:0]                 wr_data,
  output logic [NUM_PREGS*2-1:0]     file_flat
);
  logic [NUM_PREGS*2-1:0] file_q;
  logic [NUM_PREGS*2-1:0] file_nxt;

  // Later assignments override earlier ones: external port first, then slots upward.
  always_comb begin
    file_nxt = file_q;
    if (wr_en) file_nxt[{wr_idx, 1'b0} +: 2] = wr_data;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slot_we[s]) file_nxt[{slot_dst[s*IDX_W +: IDX_W], 1'b0} +: 2] = slot_res[s*2 +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) file_q <= '0;
    else     file_q <= file_nxt;
  end

  assign file_flat = file_q;
endmodule

// File: rtl/cplu_operand_sel.sv
module cplu_operand_sel
  import cplu_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int IDX_W     = 5
) (
  input  pred_t                      file_val,
  input  logic [IDX_W-1:0]           idx,
  input  logic [NUM_SLOTS-1:0]       prod_we,
  input  logic [NUM_SLOTS*IDX_W-1:0] prod_dst,
  input  logic [NUM_SLOTS*2-1:0]     prod_res,
  output pred_t                      sel
);
  // Highest-numbered matching first-group producer wins.
  always_comb begin
    sel = file_val;
    for (int f = 0; f < NUM_SLOTS; f++) begin
      if (prod_we[f] && prod_dst[f*IDX_W +: IDX_W] == idx) sel = prod_res[f*2 +: 2];
    end
  end
endmodule

// File: rtl/cplu_qualify.sv
module cplu_qualify
  import cplu_pkg::*;
#(
  parameter int NUM_PREGS = 32,
  parameter int NUM_QUAL  = 6,
  parameter int IDX_W     = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PREGS*2-1:0]    file_flat,
  input  logic [NUM_QUAL-1:0]       qual_use,
  input  logic [NUM_QUAL-1:0]       qual_neg,
  input  logic [NUM_QUAL*IDX_W-1:0] qual_idx,
  output logic [NUM_QUAL*2-1:0]     qual_src,
  output logic [NUM_QUAL-1:0]       qual_en
);
  logic [NUM_QUAL-1:0] en_nxt;

  for (genvar i = 0; i < NUM_QUAL; i++) begin : g_q
    logic [IDX_W-1:0] qi;
    assign qi              = qual_idx[i*IDX_W +: IDX_W];
    assign qual_src[i*2 +: 2] = file_flat[{qi, 1'b0} +: 2];
    assign en_nxt[i]       = !qual_use[i] || qual_eval(qual_src[i*2 +: 2], qual_neg[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) qual_en <= '0;
    else     qual_en <= en_nxt;
  end
endmodule

// File: rtl/chained_pred_unit.sv
module chained_pred_unit
  import cplu_pkg::*;
#(
  parameter int NUM_PREGS = 32,
  parameter int NUM_SLOTS = 3,
  parameter int NUM_QUAL  = 6,
  localparam int IDX_W    = $clog2(NUM_PREGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SLOTS-1:0]       op_vld,
  input  logic [NUM_SLOTS-1:0]       op_grp,
  input  logic [NUM_SLOTS*2-1:0]     op_code,
  input  logic [NUM_SLOTS*IDX_W-1:0] op_src_a,
  input  logic [NUM_SLOTS-1:0]       op_inv_a,
  input  logic [NUM_SLOTS*IDX_W-1:0] op_src_b,
  input  logic [NUM_SLOTS-1:0]       op_inv_b,
  input  logic [NUM_SLOTS*IDX_W-1:0] op_dst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [1:0]                 wr_data,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [1:0]                 rd_data,
  input  logic [NUM_QUAL-1:0]        qual_use,
  input  logic [NUM_QUAL-1:0]        qual_neg,
  input  logic [NUM_QUAL*IDX_W-1:0]  qual_idx,
  output logic [NUM_QUAL-1:0]        qual_en
);
  function automatic pred_t pick(input logic [NUM_PREGS*2-1:0] f, input logic [IDX_W-1:0] i);
    return f[{i, 1'b0} +: 2];
  endfunction

  // Named internal events, also observed by the bound checker.
  logic [NUM_PREGS*2-1:0] file_flat;
  logic [NUM_SLOTS-1:0]   g1_we;
  logic [NUM_SLOTS*2-1:0] g1_res;
  logic [NUM_SLOTS-1:0]   slot_we;
  logic [NUM_SLOTS*2-1:0] slot_res;
  logic [NUM_SLOTS*2-1:0] opa_flat;
  logic [NUM_SLOTS*2-1:0] opb_flat;
  logic [NUM_QUAL*2-1:0]  qual_src;

  // First half: every slot evaluates on file operands.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_first
    pl_op_e code;
    pred_t  opa_f;
    pred_t  opb_f;
    assign code       = pl_op_e'(op_code[s*2 +: 2]);
    assign opa_f      = pick(file_flat, op_src_a[s*IDX_W +: IDX_W]);
    assign opb_f      = pick(file_flat, op_src_b[s*IDX_W +: IDX_W]);
    assign g1_res[s*2 +: 2] = pl_eval(code, opa_f, opb_f, op_inv_a[s], op_inv_b[s]);
    assign g1_we[s]   = op_vld[s] && !op_grp[s] && (code != PL_NOP);
  end

  // Second half: operands may be replaced by first-half results.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_second
    pred_t opa_g2;
    pred_t opb_g2;
    pred_t res_g2;

    cplu_operand_sel #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_sel_a (
      .file_val (g_first[s].opa_f),
      .idx      (op_src_a[s*IDX_W +: IDX_W]),
      .prod_we  (g1_we),
      .prod_dst (op_dst),
      .prod_res (g1_res),
      .sel      (opa_g2)
    );
    cplu_operand_sel #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_sel_b (
      .file_val (g_first[s].opb_f),
      .idx      (op_src_b[s*IDX_W +: IDX_W]),
      .prod_we  (g1_we),
      .prod_dst (op_dst),
      .prod_res (g1_res),
      .sel      (opb_g2)
    );

    assign res_g2 = pl_eval(g_first[s].code, opa_g2, opb_g2, op_inv_a[s], op_inv_b[s]);
    assign opa_flat[s*2 +: 2] = op_grp[s] ? opa_g2 : g_first[s].opa_f;
    assign opb_flat[s*2 +: 2] = op_grp[s] ? opb_g2 : g_first[s].opb_f;
    assign slot_res[s*2 +: 2] = op_grp[s] ? res_g2 : g1_res[s*2 +: 2];
    assign slot_we[s]         = op_vld[s] && (g_first[s].code != PL_NOP);
  end

  cplu_pred_file #(.NUM_PREGS(NUM_PREGS), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_file (
    .clk       (clk),
    .rst       (rst),
    .slot_we   (slot_we),
    .slot_dst  (op_dst),
    .slot_res  (slot_res),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .file_flat (file_flat)
  );

  cplu_qualify #(.NUM_PREGS(NUM_PREGS), .NUM_QUAL(NUM_QUAL), .IDX_W(IDX_W)) u_qual (
    .clk       (clk),
    .rst       (rst),
    .file_flat (file_flat),
    .qual_use  (qual_use),
    .qual_neg  (qual_neg),
    .qual_idx  (qual_idx),
    .qual_src  (qual_src),
    .qual_en   (qual_en)
  );

  assign rd_data = pick(file_flat, rd_idx);
endmodule

// File: rtl/cplu_chk.sv
module cplu_chk #(
  parameter int NUM_PREGS = 32,
  parameter int NUM_SLOTS = 3,
  parameter int NUM_QUAL  = 6
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic [NUM_SLOTS-1:0]   slot_we,
  input logic [NUM_PREGS*2-1:0] file_flat,
  input logic [NUM_SLOTS*2-1:0] opa_flat,
  input logic [NUM_SLOTS*2-1:0] opb_flat,
  input logic [NUM_SLOTS*2-1:0] slot_res,
  input logic [NUM_QUAL-1:0]    qual_use,
  input logic [NUM_QUAL*2-1:0]  qual_src,
  input logic [NUM_QUAL-1:0]    qual_en
);
  // R11: no writer means the whole file keeps its contents.
  assert_idle_file_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && slot_we == '0) |=> $stable(file_flat));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    // R3: an invalid operand must give the all-zero flag.
    assert_invalid_operand_R3: assert property (@(posedge clk) disable iff (rst)
      (!opa_flat[s*2+1] || !opb_flat[s*2+1]) |-> (slot_res[s*2 +: 2] == 2'b00));
  end

  for (genvar i = 0; i < NUM_QUAL; i++) begin : g_qual
    // R8: an unused selector opens its enable on the next cycle.
    assert_unused_qual_open_R8: assert property (@(posedge clk) disable iff (rst)
      !qual_use[i] |=> qual_en[i]);
    // R9: an invalid selected flag closes the enable on the next cycle.
    assert_invalid_qual_closed_R9: assert property (@(posedge clk) disable iff (rst)
      (qual_use[i] && !qual_src[i*2+1]) |=> !qual_en[i]);
  end
endmodule

bind chained_pred_unit cplu_chk #(
  .NUM_PREGS (NUM_PREGS),
  .NUM_SLOTS (NUM_SLOTS),
  .NUM_QUAL  (NUM_QUAL)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .slot_we   (slot_we),
  .file_flat (file_flat),
  .opa_flat  (opa_flat),
  .opb_flat  (opb_flat),
  .slot_res  (slot_res),
  .qual_use  (qual_use),
  .qual_src  (qual_src),
  .qual_en   (qual_en)
);

// File: tb/chained_pred_unit_tb.sv
`timescale 1ns/1ps
module chained_pred_unit_tb;
  localparam int NP = 32;
  localparam int NS = 3;
  localparam int NQ = 6;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0]    op_vld = '0, op_grp = '0, op_inv_a = '0, op_inv_b = '0;
  logic [NS*2-1:0]  op_code = '0;
  logic [NS*IW-1:0] op_src_a = '0, op_src_b = '0, op_dst = '0;
  logic             wr_en = 1'b0;
  logic [IW-1:0]    wr_idx = '0, rd_idx = '0;
  logic [1:0]       wr_data = '0, rd_data;
  logic [NQ-1:0]    qual_use = '0, qual_neg = '0, qual_en;
  logic [NQ*IW-1:0] qual_idx = '0;

  always #10 clk = ~clk;

  chained_pred_unit #(.NUM_PREGS(NP), .NUM_SLOTS(NS), .NUM_QUAL(NQ)) u_dut (
    .clk(clk), .rst(rst), .op_vld(op_vld), .op_grp(op_grp), .op_code(op_code),
    .op_src_a(op_src_a), .op_inv_a(op_inv_a), .op_src_b(op_src_b), .op_inv_b(op_inv_b),
    .op_dst(op_dst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .qual_use(qual_use), .qual_neg(qual_neg),
    .qual_idx(qual_idx), .qual_en(qual_en)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Bench-side instruction description and flag model.
  logic [1:0] model [NP];
  logic       b_vld [NS], b_grp [NS], b_ia [NS], b_ib [NS];
  logic [1:0] b_code [NS];
  int         b_sa [NS], b_sb [NS], b_dst [NS];
  logic       q_use [NQ], q_neg [NQ];
  int         q_idx [NQ];
  logic       b_wen;
  int         b_widx;
  logic [1:0] b_wdata;

  logic [NQ-1:0] exp_q [$];

  // Own restatement of R2/R3.
  function automatic logic [1:0] ref_op(logic [1:0] code, logic [1:0] a, logic [1:0] b,
                                        logic ia, logic ib);
    logic va, vb;
    if (a[1] == 1'b0 || b[1] == 1'b0) return 2'b00;
    va = ia ? ~a[0] : a[0];
    vb = ib ? ~b[0] : b[0];
    if (code == 2'd0) return {1'b1, va & vb};
    if (code == 2'd1) return {1'b1, va | vb};
    return {1'b1, va & ~vb};
  endfunction

  task automatic clear_instr();
    for (int s = 0; s < NS; s++) begin
      b_vld[s] = 0; b_grp[s] = 0; b_ia[s] = 0; b_ib[s] = 0;
      b_code[s] = 2'd3; b_sa[s] = 0; b_sb[s] = 0; b_dst[s] = 0;
    end
    for (int i = 0; i < NQ; i++) begin q_use[i] = 0; q_neg[i] = 0; q_idx[i] = 0; end
    b_wen = 0; b_widx = 0; b_wdata = 2'b00;
  endtask

  task automatic set_slot(int s, logic grp, logic [1:0] code, int sa, logic ia,
                          int sb, logic ib, int dst);
    b_vld[s] = 1; b_grp[s] = grp; b_code[s] = code;
    b_sa[s] = sa; b_ia[s] = ia; b_sb[s] = sb; b_ib[s] = ib; b_dst[s] = dst;
  endtask

  task automatic set_qual(int i, int idx, logic neg);
    q_use[i] = 1; q_idx[i] = idx; q_neg[i] = neg;
  endtask

  // Driver: presents one instruction, predicts qualify enables and new flags.
  task automatic issue();
    logic [NQ-1:0] eq;
    logic [1:0] r1 [NS];
    logic [1:0] res [NS];
    logic [1:0] a, b;
    @(negedge clk);
    for (int s = 0; s < NS; s++) begin
      op_vld[s] = b_vld[s]; op_grp[s] = b_grp[s]; op_code[s*2 +: 2] = b_code[s];
      op_src_a[s*IW +: IW] = IW'(b_sa[s]); op_inv_a[s] = b_ia[s];
      op_src_b[s*IW +: IW] = IW'(b_sb[s]); op_inv_b[s] = b_ib[s];
      op_dst[s*IW +: IW] = IW'(b_dst[s]);
    end
    for (int i = 0; i < NQ; i++) begin
      qual_use[i] = q_use[i]; qual_neg[i] = q_neg[i]; qual_idx[i*IW +: IW] = IW'(q_idx[i]);
      if (!q_use[i]) eq[i] = 1'b1;
      else eq[i] = model[q_idx[i]][1] && (model[q_idx[i]][0] != q_neg[i]);
    end
    wr_en = b_wen; wr_idx = IW'(b_widx); wr_data = b_wdata;
    exp_q.push_back(eq);
    for (int s = 0; s < NS; s++)
      r1[s] = ref_op(b_code[s], model[b_sa[s]], model[b_sb[s]], b_ia[s], b_ib[s]);
    for (int s = 0; s < NS; s++) begin
      if (!b_grp[s]) res[s] = r1[s];
      else begin
        a = model[b_sa[s]]; b = model[b_sb[s]];
        for (int f = 0; f < NS; f++) begin
          if (b_vld[f] && !b_grp[f] && b_code[f] != 2'd3) begin
            if (b_dst[f] == b_sa[s]) a = r1[f];
            if (b_dst[f] == b_sb[s]) b = r1[f];
          end
        end
        res[s] = ref_op(b_code[s], a, b, b_ia[s], b_ib[s]);
      end
    end
    if (b_wen) model[b_widx] = b_wdata;
    for (int s = 0; s < NS; s++)
      if (b_vld[s] && b_code[s] != 2'd3) model[b_dst[s]] = res[s];
  endtask

  task automatic go_idle();
    op_vld = '0; qual_use = '0; wr_en = 1'b0;
  endtask

  task automatic rd_exp(int idx, logic [1:0] exp, string tag);
    @(negedge clk);
    go_idle();
    rd_idx = IW'(idx);
    #1;
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s flag %0d actual=%b expected=%b", tag, idx, rd_data, exp);
    end
  endtask

  task automatic rd_model(int idx, string tag);
    rd_exp(idx, model[idx], tag);
  endtask

  // Monitor: compares registered qualify enables one edge after issue (R8).
  initial begin
    logic [NQ-1:0] e;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_chk++;
        if (qual_en !== e) begin
          n_bad++;
          $display("FAIL R8 qual_en actual=%b expected=%b", qual_en, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all) actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    for (int k = 0; k < NP; k++) model[k] = 2'b00;
    clear_instr();
    repeat (3) @(negedge clk);
    n_chk++;
    if (qual_en !== '0) begin
      n_bad++;
      $display("FAIL R1 qual_en in reset actual=%b expected=%b", qual_en, {NQ{1'b0}});
    end
    rst = 1'b0;
    for (int k = 0; k < NP; k++) rd_exp(k, 2'b00, "R1");

    // R7: external writes.
    clear_instr(); b_wen = 1; b_widx = 1; b_wdata = 2'b11; issue();
    clear_instr(); b_wen = 1; b_widx = 2; b_wdata = 2'b10; issue();
    clear_instr(); b_wen = 1; b_widx = 3; b_wdata = 2'b01; issue();
    rd_exp(1, 2'b11, "R7"); rd_exp(2, 2'b10, "R7"); rd_exp(3, 2'b01, "R10");

    // R2: opcodes and inversion in the first group.
    clear_instr();
    set_slot(0, 0, 2'd0, 1, 0, 2, 0, 4);
    set_slot(1, 0, 2'd1, 1, 1, 2, 0, 5);
    set_slot(2, 0, 2'd2, 1, 0, 2, 0, 6);
    issue();
    rd_exp(4, 2'b10, "R2"); rd_exp(5, 2'b10, "R2"); rd_exp(6, 2'b11, "R2");

    // R3: invalid operand gives 2'b00.
    clear_instr();
    set_slot(0, 0, 2'd0, 3, 0, 1, 0, 4);
    set_slot(1, 0, 2'd1, 1, 0, 0, 0, 6);
    issue();
    rd_exp(4, 2'b00, "R3"); rd_exp(6, 2'b00, "R3");

    // R4: chaining within one instruction.
    clear_instr();
    set_slot(0, 0, 2'd1, 2, 1, 2, 0, 7);
    set_slot(1, 1, 2'd0, 7, 0, 1, 0, 8);
    set_slot(2, 1, 2'd1, 7, 1, 2, 0, 11);
    issue();
    rd_exp(7, 2'b11, "R4"); rd_exp(8, 2'b11, "R4"); rd_exp(11, 2'b10, "R4");

    // R4/R6: two first-group producers, highest one forwarded and kept.
    clear_instr();
    set_slot(0, 0, 2'd0, 1, 0, 1, 0, 12);
    set_slot(1, 0, 2'd0, 1, 0, 2, 0, 12);
    set_slot(2, 1, 2'd1, 12, 0, 2, 0, 13);
    issue();
    rd_exp(12, 2'b10, "R6"); rd_exp(13, 2'b10, "R4");

    // R6: slot-to-slot and slot-over-port priority.
    clear_instr();
    set_slot(0, 0, 2'd0, 1, 0, 1, 0, 14);
    set_slot(2, 0, 2'd0, 1, 0, 2, 0, 14);
    set_slot(1, 0, 2'd1, 2, 0, 2, 0, 15);
    b_wen = 1; b_widx = 15; b_wdata = 2'b11;
    issue();
    rd_exp(14, 2'b10, "R6"); rd_exp(15, 2'b10, "R6");

    // R5/R8/R9: reads see the pre-instruction file; qualifier cases.
    clear_instr();
    set_slot(0, 0, 2'd1, 14, 0, 14, 0, 16);
    set_slot(1, 0, 2'd1, 14, 1, 14, 0, 14);
    set_qual(0, 14, 0); set_qual(1, 1, 0); set_qual(2, 1, 1);
    set_qual(3, 3, 1);  set_qual(4, 0, 0);
    issue();
    rd_exp(16, 2'b10, "R5"); rd_exp(14, 2'b11, "R5");
    clear_instr(); set_qual(0, 14, 1); set_qual(3, 3, 0); issue();

    // R11: idle slot and opcode 3 write nothing.
    clear_instr();
    set_slot(0, 0, 2'd3, 2, 1, 2, 1, 1);
    b_vld[1] = 0; b_code[1] = 2'd0; b_sa[1] = 3; b_dst[1] = 2;
    issue();
    rd_exp(1, 2'b11, "R11"); rd_exp(2, 2'b10, "R11");

    // Pseudo-random instructions against the model (R4, R5, R6).
    lf = 32'h1d2c_3b4a;
    for (int n = 0; n < 80; n++) begin
      clear_instr();
      for (int s = 0; s < NS; s++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        b_vld[s] = lf[0]; b_grp[s] = lf[1]; b_code[s] = lf[3:2];
        b_ia[s] = lf[4]; b_ib[s] = lf[5];
        b_sa[s] = int'(lf[9:6]); b_sb[s] = int'(lf[13:10]); b_dst[s] = int'(lf[17:14]);
      end
      for (int i = 0; i < NQ; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        q_use[i] = lf[0]; q_neg[i] = lf[1]; q_idx[i] = int'(lf[5:2]);
      end
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      b_wen = lf[0]; b_widx = int'(lf[4:1]); b_wdata = lf[6:5];
      issue();
    end
    for (int k = 0; k < 16; k++) rd_model(k, "R6");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule